// File: doc/BRIEF.md
# Interrupt Status and Keyed Reset Control Registers

This block holds the pending and active state of a configurable set of external interrupt lines and presents it through two 32-bit registers on a simple word bus. External line `n` is known to software as exception `16+n`, and exception number 0 means "none". A pulse on a line marks it pending. An acknowledge strobe from the core side takes the lowest-numbered line that is pending and not already active, makes it the current exception and saves the previous one on a small nesting stack. A completion strobe retires the current exception and brings back the one beneath it.

The status register at offset `0xD04` reports the current exception, the lowest eligible pending exception, whether any line is pending at all, and whether retiring the current exception would return the core to base level. The reset control register at offset `0xD0C` accepts writes only when a 16-bit key is present in the upper half. A keyed write can request a system reset, which appears as a one-cycle pulse. It raises a sticky flag when it asks for functions this block does not carry out. Register reads return their data one clock after the read strobe.

Top module: `sysIrqCtl`

## Requirements
- R1: A write to offset 0xD0C whose bits 31:16 differ from 0x05FA changes neither `resetReq` nor `unsupFlag`.
- R2: A write to 0xD0C carrying key 0x05FA with bit 2 set drives `resetReq` high for exactly the one cycle after the write edge.
- R3: A keyed write to 0xD0C with bit 0 or bit 1 set sets `unsupFlag`. The flag stays set until reset, and the write does not raise `resetReq` unless bit 2 is also set.
- R4: A keyed write to 0xD0C with a nonzero value in bits 10:8 sets `unsupFlag`.
- R5: Status bits 8:0 hold the current exception number (16+n for line n), or 0 when no exception is active.
- R6: Status bits 20:12 hold 16+n for the lowest line n that is pending and not active, or 0 when no such line exists.
- R7: Status bit 22 is 1 whenever any line is pending, whether or not that line is active.
- R8: Status bit 11 is 1 exactly when no exception other than the current one is active.
- R9: An acknowledge takes the lowest eligible pending line: it clears its pending bit, marks it active and makes it current. The acknowledge is ignored if no line is eligible or if `STACK_DEPTH` exceptions are already active. A pulse that arrives in the same cycle as the clearing wins, so the line stays pending.
- R10: A completion clears the current exception's active bit and restores the previously current exception. It is ignored when nothing is active, and it takes precedence over an acknowledge in the same cycle.
- R11: Reads of any offset other than 0xD04 and 0xD0C return zero, and writes to any offset other than 0xD0C have no effect. Read data appears the cycle after the read strobe.
- R12: Synchronous active-high `rst` clears all pending, active and stack state, `unsupFlag` and `resetReq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irqPulse | input | NUM_LINES | One-cycle set pulse per external line |
| ackStrobe | input | 1 | Take the lowest eligible pending line |
| doneStrobe | input | 1 | Retire the current exception |
| busAddr | input | 12 | Byte offset of the register access |
| busWrEn | input | 1 | Write strobe |
| busRdEn | input | 1 | Read strobe |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data, valid one cycle after busRdEn |
| resetReq | output | 1 | One-cycle system reset request |
| unsupFlag | output | 1 | Sticky flag for requested but unsupported functions |

## Verification
A corrupted pending or active vector shows up on the very next status read: the pending field names the wrong line, or bit 11 flips because an extra or a missing active bit changes the return-to-base answer. A stack that loses an entry stays hidden until the matching completion. At that point the active field reports the wrong exception one cycle later. The key gate and the reset pulse are visible directly on `resetReq` and `unsupFlag` one cycle after the write, so the bench samples both pins on that cycle and on the cycle after it.

// File: rtl/sysIrqCtlPkg.sv
package sysIrqCtlPkg;
  localparam int EXC_W = 9;
  localparam int EXT_BASE = 16;
  localparam logic [11:0] OFS_STATUS = 12'hD04;
  localparam logic [11:0] OFS_RESETCTL = 12'hD0C;
  localparam logic [15:0] WR_KEY = 16'h05FA;

  typedef struct packed {
    logic take;
    logic retire;
    logic readStatus;
  } ctlStrobes_t;
endpackage

// File: rtl/sysIrqCtlBus.sv
module sysIrqCtlBus
  import sysIrqCtlPkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic [11:0] busAddr,
  input  logic        busWrEn,
  input  logic        busRdEn,
  input  logic [31:0] busWrData,
  input  logic        ackStrobe,
  input  logic        doneStrobe,
  output ctlStrobes_t strobes,
  output logic        resetReq,
  output logic        unsupFlag
);
  logic keyedWrite;
  logic wantsUnsup;

  always_comb begin
    keyedWrite = busWrEn && (busAddr == OFS_RESETCTL) && (busWrData[31:16] == WR_KEY);
    wantsUnsup = (|busWrData[1:0]) || (|busWrData[10:8]);
    strobes.retire = doneStrobe;
    strobes.take = ackStrobe && !doneStrobe;
    strobes.readStatus = busRdEn && (busAddr == OFS_STATUS);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      resetReq <= 1'b0;
      unsupFlag <= 1'b0;
    end else begin
      resetReq <= keyedWrite && busWrData[2];
      if (keyedWrite && wantsUnsup) unsupFlag <= 1'b1;
    end
  end

  // R3
  unsup_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    unsupFlag |=> unsupFlag);

  // R1
  key_gate_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(unsupFlag) |-> $past(busWrData[31:16] == WR_KEY && busWrEn));

  // R2
  reset_pulse_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(resetReq) |-> $past(busWrEn && busAddr == OFS_RESETCTL));
endmodule

// File: rtl/sysIrqCtlPath.sv
module sysIrqCtlPath
  import sysIrqCtlPkg::*;
#(
  parameter int NUM_LINES = 64,
  parameter int STACK_DEPTH = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] irqPulse,
  input  ctlStrobes_t          strobes,
  output logic [31:0]          rdData
);
  localparam int LINE_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;
  localparam int DW = $clog2(STACK_DEPTH + 1);

  logic [NUM_LINES-1:0] pendingQ, activeQ, eligible, pendNext, actNext, otherAct;
  logic [EXC_W-1:0]     curExc, curOff, popExc, pendExc;
  logic [EXC_W-1:0]     stackQ [STACK_DEPTH];
  logic [DW-1:0]        depthQ;
  logic [LINE_W-1:0]    pickIdx, curLine;
  logic                 pickValid, roomy, doTake, doRetire, retBase;
  logic [31:0]          statusWord;

  always_comb begin
    eligible = pendingQ & ~activeQ;
    pickValid = 1'b0;
    pickIdx = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (eligible[i]) begin
        pickValid = 1'b1;
        pickIdx = LINE_W'(i);
      end
    end
    curOff = curExc - EXC_W'(EXT_BASE);
    curLine = curOff[LINE_W-1:0];
    roomy = depthQ < DW'(STACK_DEPTH);
    doTake = strobes.take && pickValid && roomy;
    doRetire = strobes.retire && (depthQ != '0);
    popExc = '0;
    for (int s = 0; s < STACK_DEPTH; s++) begin
      if (depthQ == DW'(s + 1)) popExc = stackQ[s];
    end
    pendNext = pendingQ;
    actNext = activeQ;
    if (doTake) begin
      pendNext[pickIdx] = 1'b0;
      actNext[pickIdx] = 1'b1;
    end
    if (doRetire) actNext[curLine] = 1'b0;
    pendNext = pendNext | irqPulse;
    otherAct = activeQ;
    if (curExc != '0) otherAct[curLine] = 1'b0;
    retBase = ~|otherAct;
    pendExc = pickValid ? (EXC_W'(EXT_BASE) + EXC_W'(pickIdx)) : '0;
    statusWord = {9'b0, |pendingQ, 1'b0, pendExc, retBase, 2'b0, curExc};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pendingQ <= '0;
      activeQ <= '0;
      curExc <= '0;
      depthQ <= '0;
      rdData <= '0;
      for (int s = 0; s < STACK_DEPTH; s++) stackQ[s] <= '0;
    end else begin
      pendingQ <= pendNext;
      activeQ <= actNext;
      rdData <= strobes.readStatus ? statusWord : 32'b0;
      if (doRetire) begin
        curExc <= popExc;
        depthQ <= depthQ - 1'b1;
      end else if (doTake) begin
        for (int s = 0; s < STACK_DEPTH; s++) begin
          if (depthQ == DW'(s)) stackQ[s] <= curExc;
        end
        curExc <= EXC_W'(EXT_BASE) + EXC_W'(pickIdx);
        depthQ <= depthQ + 1'b1;
      end
    end
  end

  // R9
  take_push_chk: assert property (@(posedge clk) disable iff (rst)
    doTake |=> (curExc != '0) && (depthQ == $past(depthQ) + 1'b1));

  // R10
  retire_pop_chk: assert property (@(posedge clk) disable iff (rst)
    doRetire |=> (depthQ == $past(depthQ) - 1'b1) && !activeQ[$past(curLine)]);

  // R8
  active_count_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(activeQ) == int'(depthQ));

  // R5
  idle_current_chk: assert property (@(posedge clk) disable iff (rst)
    (depthQ == '0) |-> (curExc == '0));
endmodule

// File: rtl/sysIrqCtl.sv
module sysIrqCtl
  import sysIrqCtlPkg::*;
#(
  parameter int NUM_LINES = 64,
  parameter int STACK_DEPTH = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] irqPulse,
  input  logic                 ackStrobe,
  input  logic                 doneStrobe,
  input  logic [11:0]          busAddr,
  input  logic                 busWrEn,
  input  logic                 busRdEn,
  input  logic [31:0]          busWrData,
  output logic [31:0]          busRdData,
  output logic                 resetReq,
  output logic                 unsupFlag
);
  ctlStrobes_t strobes;

  sysIrqCtlBus ctl (
    .clk(clk), .rst(rst), .busAddr(busAddr), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .busWrData(busWrData), .ackStrobe(ackStrobe),
    .doneStrobe(doneStrobe), .strobes(strobes), .resetReq(resetReq),
    .unsupFlag(unsupFlag)
  );

  sysIrqCtlPath #(.NUM_LINES(NUM_LINES), .STACK_DEPTH(STACK_DEPTH)) path (
    .clk(clk), .rst(rst), .irqPulse(irqPulse), .strobes(strobes),
    .rdData(busRdData)
  );
endmodule

// File: tb/sysIrqCtl_test.sv
module sysIrqCtl_test;
  localparam int L = 64;
  logic clk = 0, rst = 1;
  logic [L-1:0] irqPulse = '0;
  logic ackStrobe = 0, doneStrobe = 0, busWrEn = 0, busRdEn = 0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWrData = '0, busRdData;
  logic resetReq, unsupFlag;
  int checks = 0, failures = 0;
  logic [31:0] expQ [$];
  string tagQ [$];
  logic rdSeen = 0;
  bit finished = 0;

  sysIrqCtl #(.NUM_LINES(L), .STACK_DEPTH(4)) uut (
    .clk(clk), .rst(rst), .irqPulse(irqPulse), .ackStrobe(ackStrobe),
    .doneStrobe(doneStrobe), .busAddr(busAddr), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .busWrData(busWrData), .busRdData(busRdData),
    .resetReq(resetReq), .unsupFlag(unsupFlag));

  always #10 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard when read data is due
  always @(posedge clk) rdSeen <= busRdEn;
  always @(negedge clk) begin
    if (rdSeen) begin
      if (expQ.size() == 0) check("R11 unexpected read", 32'h1, 32'h0);
      else check(tagQ.pop_front(), busRdData, expQ.pop_front());
    end
  end

  task automatic doRead(input logic [11:0] a, input logic [31:0] e, input string tag);
    busAddr = a; busRdEn = 1; expQ.push_back(e); tagQ.push_back(tag);
    @(negedge clk); busRdEn = 0;
    @(negedge clk);
  endtask

  task automatic doWrite(input logic [11:0] a, input logic [31:0] d);
    busAddr = a; busWrData = d; busWrEn = 1;
    @(negedge clk); busWrEn = 0;
  endtask

  task automatic strobe(input logic [L-1:0] m, input logic a, input logic d);
    irqPulse = m; ackStrobe = a; doneStrobe = d;
    @(negedge clk); irqPulse = '0; ackStrobe = 0; doneStrobe = 0;
  endtask

  task automatic doReset();
    rst = 1; repeat (2) @(negedge clk); rst = 0; @(negedge clk);
  endtask

  initial begin
    #(20 * 200000);
    failures++; checks++;
    $display("FAIL watchdog R12 actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0; @(negedge clk);
    check("R12 resetReq after reset", 32'(resetReq), 0);
    check("R12 unsupFlag after reset", 32'(unsupFlag), 0);
    doRead(12'hD04, 32'h0000_0800, "R12 R8 status idle");
    doRead(12'hD0C, 32'h0, "R11 reset ctl reads zero");
    doRead(12'hD08, 32'h0, "R11 other offset reads zero");

    // R1 wrong key
    doWrite(12'hD0C, 32'h1234_0004);
    check("R1 no pulse on bad key", 32'(resetReq), 0);
    doWrite(12'hD0C, 32'h05FB_0707);
    check("R1 no flag on bad key", 32'(unsupFlag), 0);
    check("R1 no pulse on bad key 2", 32'(resetReq), 0);

    // R11 key on other offsets
    doWrite(12'hD04, 32'h05FA_0007);
    check("R11 write to status ignored pulse", 32'(resetReq), 0);
    check("R11 write to status ignored flag", 32'(unsupFlag), 0);

    // R2 valid reset request
    doWrite(12'hD0C, 32'h05FA_0004);
    check("R2 pulse high", 32'(resetReq), 1);
    @(negedge clk);
    check("R2 pulse one cycle", 32'(resetReq), 0);
    check("R2 no flag", 32'(unsupFlag), 0);

    // R6 R7 pending report
    strobe(64'h28, 0, 0);
    doRead(12'hD04, 32'h0041_3800, "R6 R7 lowest pending");
    strobe('0, 1, 0);
    doRead(12'hD04, 32'h0041_5813, "R9 R5 first take");
    strobe('0, 1, 0);
    doRead(12'hD04, 32'h0000_0015, "R8 nested not base");
    strobe('0, 0, 1);
    doRead(12'hD04, 32'h0000_0813, "R10 restore previous");
    strobe('0, 0, 1);
    doRead(12'hD04, 32'h0000_0800, "R10 back to idle");
    strobe('0, 0, 1);
    strobe('0, 1, 0);
    doRead(12'hD04, 32'h0000_0800, "R9 R10 idle strobes ignored");

    // R9 depth limit
    strobe(64'h1F, 0, 0);
    for (int k = 0; k < 5; k++) strobe('0, 1, 0);
    doRead(12'hD04, 32'h0041_4013, "R9 depth limit");
    strobe('0, 1, 1);
    doRead(12'hD04, 32'h0041_4012, "R10 completion beats acknowledge");
    strobe(64'h10, 1, 0);
    doRead(12'hD04, 32'h0040_0014, "R9 R7 pulse wins over clear");

    // R12 reset clears state
    doReset();
    doRead(12'hD04, 32'h0000_0800, "R12 state cleared");

    // R6 top line
    strobe(64'h8000_0000_0000_0000, 0, 0);
    doRead(12'hD04, 32'h0044_F800, "R6 highest line");

    // R4 grouping field
    doWrite(12'hD0C, 32'h05FA_0100);
    check("R4 grouping sets flag", 32'(unsupFlag), 1);
    check("R4 no pulse", 32'(resetReq), 0);
    @(negedge clk);
    check("R3 flag sticky", 32'(unsupFlag), 1);

    doReset();
    check("R12 flag cleared", 32'(unsupFlag), 0);
    doWrite(12'hD0C, 32'h05FA_0002);
    check("R3 clear-active sets flag", 32'(unsupFlag), 1);
    check("R3 no pulse", 32'(resetReq), 0);
    doReset();
    doWrite(12'hD0C, 32'h05FA_0001);
    check("R3 local reset sets flag", 32'(unsupFlag), 1);

    repeat (3) @(negedge clk);
    check("R11 scoreboard drained", 32'(expQ.size()), 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule